// File: doc/BRIEF.md
# Tagged Micro Translation Cache

This block is a small, fully associative store of recent virtual-to-physical page translations. It sits between a requester and a larger second-level translation cache. Every cycle the requester may present a virtual page number together with the current address-space tag and the security-state bit. In the same cycle the block answers with a hit flag, the physical frame, a permission-fault flag and a flag for an ambiguous multi-entry match. The block holds no pending state for a miss. The requester obtains the translation from the next level and writes it in through the refill port. The block picks the slot to overwrite itself.

Each slot stores a page number, a frame, an 8-bit address-space tag, a security bit, a global flag, a 2-bit access code, an execute-never bit and a low-order size mask. Set mask bits widen the slot to a larger page. Software-visible maintenance is reduced to two pulses. One clears every slot. The other clears the non-global slots that belong to one address space. When the store is full, the overwrite choice follows either a rotating pointer or a free-running pseudo-random sequence, chosen by a mode input.

Top module: `xlt_micro_cache`

## Requirements
- R1: Lookup is purely combinational against the stored slots. lk_hit, lk_pfn, lk_fault and lk_multi reflect the inputs of the same cycle. All four are 0 whenever lk_valid is 0, and lk_pfn is 0 on a miss.
- R2: A slot matches when it is valid, its page number equals lk_vpn outside its mask bits, and its security bit equals lk_ns. Its address-space tag must also equal lk_asid, unless the slot is global.
- R3: A set bit k of a slot's MASK_W-bit size mask removes page-number bit k from the comparison. On a hit, frame bit k is taken from lk_vpn bit k instead of from the stored frame.
- R4: The access code is 00 for no access, 01 for read-only, and 10 or 11 for read/write. lk_fault is 1 only on a hit, and only when one of these holds: the code is 00; lk_write is 1 and the code is 01; lk_exec is 1 and the execute-never bit is set.
- R5: When two or more slots match, the lowest-index slot supplies the frame and the fault, and lk_multi is 1. lk_multi is 0 when at most one slot matches.
- R6: A refill writes the lowest-index invalid slot when one exists. The write becomes visible on the next cycle.
- R7: With repl_random at 0 and all slots valid, a refill overwrites the slot named by a rotating pointer. The pointer starts at 0 and steps by one, wrapping, on each such refill only.
- R8: With repl_random at 1 and all slots valid, the victim is the low log2(N_ENTRIES) bits of a 16-bit right-shifting Galois LFSR. The LFSR uses mask 0xB400 and seed 0xACE1, and advances on every clock out of reset. Refills in this mode leave the rotating pointer unchanged.
- R9: An inv_all pulse clears every slot for the next cycle.
- R10: An inv_asid_en pulse clears every non-global slot whose tag equals inv_asid, whatever its security bit. Global slots and slots with other tags stay valid.
- R11: A refill in the same cycle as either invalidate picks its victim from the state before the invalidate. The new slot survives the invalidate.
- R12: While rst_n is low, all slots are invalid, the pointer is 0 and the LFSR holds its seed, so every lookup misses.
- R13: A lookup in the same cycle as a refill sees the contents from before the refill. A cycle with no refill and no invalidate changes no slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_ns | input | 1 | Current security-state bit |
| lk_write | input | 1 | Access is a write |
| lk_exec | input | 1 | Access is an instruction fetch |
| lk_hit | output | 1 | Translation found |
| lk_pfn | output | PFN_W | Physical frame number |
| lk_fault | output | 1 | Access not permitted by the matching slot |
| lk_multi | output | 1 | More than one slot matched |
| rf_valid | input | 1 | Refill write strobe |
| rf_vpn | input | VPN_W | Refill page number |
| rf_mask | input | MASK_W | Refill size mask |
| rf_asid | input | ASID_W | Refill address-space tag |
| rf_ns | input | 1 | Refill security bit |
| rf_global | input | 1 | Refill is global |
| rf_pfn | input | PFN_W | Refill frame number |
| rf_perm | input | 2 | Refill access code |
| rf_xn | input | 1 | Refill execute-never bit |
| inv_all | input | 1 | Clear every slot |
| inv_asid_en | input | 1 | Clear non-global slots of one address space |
| inv_asid | input | ASID_W | Address space to clear |
| repl_random | input | 1 | 1 selects pseudo-random victims, 0 the rotating pointer |

## Verification
A refill and an invalidate can land in the same clock edge. This is the most delicate overlap: the victim must come from the old state, and the freshly written slot must not be swept away even when its tag equals the one being cleared. The bench drives a refill tagged with address space 5 together with an inv_asid pulse for 5, and likewise a refill together with inv_all. It then looks up both the new slot and the older slots of that tag. A lookup can also coincide with a refill. The bench presents the refilled page in that same cycle and expects a miss, then a hit one cycle later. A behavioural reference model applies invalidates before the refill write and judges every cycle of these directed cases and of a long randomized mix.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
   // access codes; code bit 1 set means the page is writable
   localparam logic [1:0] PERM_NONE = 2'b00;
   localparam logic [1:0] PERM_RO   = 2'b01;

   function automatic logic perm_fault(input logic [1:0] code, input logic xn,
                                       input logic wr, input logic ex);
      return (code == PERM_NONE) || (wr && code == PERM_RO) || (ex && xn);
   endfunction
endpackage

// File: rtl/xlt_entry_array.sv
module xlt_entry_array #(
   parameter int N      = 32,
   parameter int VPN_W  = 20,
   parameter int PFN_W  = 20,
   parameter int ASID_W = 8,
   parameter int MASK_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [VPN_W-1:0]      q_vpn,
   input  logic [ASID_W-1:0]     q_asid,
   input  logic                  q_ns,
   output logic [N-1:0]          match_vec,
   output logic [N-1:0]          valid_vec,
   output logic [PFN_W-1:0]      e_pfn  [N],
   output logic [MASK_W-1:0]     e_mask [N],
   output logic [1:0]            e_perm [N],
   output logic                  e_xn   [N],
   input  logic                  wr_en,
   input  logic [$clog2(N)-1:0]  wr_idx,
   input  logic [VPN_W-1:0]      wr_vpn,
   input  logic [MASK_W-1:0]     wr_mask,
   input  logic [ASID_W-1:0]     wr_asid,
   input  logic                  wr_ns,
   input  logic                  wr_global,
   input  logic [PFN_W-1:0]      wr_pfn,
   input  logic [1:0]            wr_perm,
   input  logic                  wr_xn,
   input  logic                  clr_all,
   input  logic                  clr_asid_en,
   input  logic [ASID_W-1:0]     clr_asid
);
   localparam int IDX_W = $clog2(N);
   localparam int HI_W  = VPN_W - MASK_W;

   for (genvar i = 0; i < N; i++) begin : g_slot
      logic              s_v, s_g, s_ns, s_xn;
      logic [VPN_W-1:0]  s_vpn;
      logic [ASID_W-1:0] s_asid;
      logic [PFN_W-1:0]  s_pfn;
      logic [MASK_W-1:0] s_mask;
      logic [1:0]        s_perm;
      logic [VPN_W-1:0]  care;
      logic              hit_here;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_v    <= 1'b0;
            s_g    <= 1'b0;
            s_ns   <= 1'b0;
            s_xn   <= 1'b0;
            s_vpn  <= '0;
            s_asid <= '0;
            s_pfn  <= '0;
            s_mask <= '0;
            s_perm <= '0;
         end else if (wr_en && wr_idx == IDX_W'(i)) begin
            s_v    <= 1'b1;
            s_g    <= wr_global;
            s_ns   <= wr_ns;
            s_xn   <= wr_xn;
            s_vpn  <= wr_vpn;
            s_asid <= wr_asid;
            s_pfn  <= wr_pfn;
            s_mask <= wr_mask;
            s_perm <= wr_perm;
         end else if (clr_all || (clr_asid_en && !s_g && s_asid == clr_asid)) begin
            s_v <= 1'b0;
         end
      end

      assign care     = ~{{HI_W{1'b0}}, s_mask};
      assign hit_here = s_v && (((s_vpn ^ q_vpn) & care) == '0) && (s_ns == q_ns)
                        && (s_g || s_asid == q_asid);

      assign match_vec[i] = hit_here;
      assign valid_vec[i] = s_v;
      assign e_pfn[i]     = s_pfn;
      assign e_mask[i]    = s_mask;
      assign e_perm[i]    = s_perm;
      assign e_xn[i]      = s_xn;
   end
endmodule

// File: rtl/xlt_hit_select.sv
module xlt_hit_select #(
   parameter int N = 32
) (
   input  logic [N-1:0]         match_vec,
   output logic                 any_hit,
   output logic                 many_hit,
   output logic [$clog2(N)-1:0] hit_idx
);
   localparam int IDX_W = $clog2(N);

   // lowest index has priority
   always_comb begin
      hit_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match_vec[i]) hit_idx = IDX_W'(i);
      end
   end

   assign any_hit  = |match_vec;
   assign many_hit = |(match_vec & (match_vec - N'(1)));
endmodule

// File: rtl/xlt_victim_sel.sv
module xlt_victim_sel #(
   parameter int                N         = 32,
   parameter int                LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         valid_vec,
   input  logic                 rand_mode,
   input  logic                 alloc,
   output logic [$clog2(N)-1:0] victim_idx
);
   localparam int IDX_W = $clog2(N);

   logic [IDX_W-1:0]  rr_ptr;
   logic [LFSR_W-1:0] lfsr;
   logic [IDX_W-1:0]  free_idx;
   logic              full;

   always_comb begin
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_vec[i]) free_idx = IDX_W'(i);
      end
   end

   assign full = &valid_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_ptr <= '0;
      end else if (alloc && full && !rand_mode) begin
         rr_ptr <= rr_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lfsr <= LFSR_SEED;
      end else begin
         lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_TAPS : '0);
      end
   end

   always_comb begin
      if (!full)          victim_idx = free_idx;
      else if (rand_mode) victim_idx = lfsr[IDX_W-1:0];
      else                victim_idx = rr_ptr;
   end
endmodule

// File: rtl/xlt_micro_cache.sv
module xlt_micro_cache #(
   parameter int                N_ENTRIES = 32,
   parameter int                VPN_W     = 20,
   parameter int                PFN_W     = 20,
   parameter int                ASID_W    = 8,
   parameter int                MASK_W    = 8,
   parameter int                LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_ns,
   input  logic              lk_write,
   input  logic              lk_exec,
   output logic              lk_hit,
   output logic [PFN_W-1:0]  lk_pfn,
   output logic              lk_fault,
   output logic              lk_multi,
   input  logic              rf_valid,
   input  logic [VPN_W-1:0]  rf_vpn,
   input  logic [MASK_W-1:0] rf_mask,
   input  logic [ASID_W-1:0] rf_asid,
   input  logic              rf_ns,
   input  logic              rf_global,
   input  logic [PFN_W-1:0]  rf_pfn,
   input  logic [1:0]        rf_perm,
   input  logic              rf_xn,
   input  logic              inv_all,
   input  logic              inv_asid_en,
   input  logic [ASID_W-1:0] inv_asid,
   input  logic              repl_random
);
   import xlt_pkg::*;

   localparam int IDX_W = $clog2(N_ENTRIES);

   if (N_ENTRIES < 2 || (N_ENTRIES & (N_ENTRIES - 1)) != 0) begin : g_bad_depth
      $error("N_ENTRIES must be a power of two of at least 2");
   end
   if (MASK_W < 1 || MASK_W >= VPN_W || MASK_W > PFN_W) begin : g_bad_mask
      $error("MASK_W must be positive, below VPN_W and at most PFN_W");
   end
   if (LFSR_W < IDX_W) begin : g_bad_lfsr
      $error("LFSR_W must cover the slot index");
   end

   logic [N_ENTRIES-1:0] match_vec, valid_vec;
   logic [PFN_W-1:0]     e_pfn  [N_ENTRIES];
   logic [MASK_W-1:0]    e_mask [N_ENTRIES];
   logic [1:0]           e_perm [N_ENTRIES];
   logic                 e_xn   [N_ENTRIES];
   logic                 any_hit, many_hit;
   logic [IDX_W-1:0]     hit_idx, victim_idx;
   logic [PFN_W-1:0]     sel_pfn, merged_pfn;
   logic [MASK_W-1:0]    sel_mask;

   xlt_entry_array #(
      .N(N_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .MASK_W(MASK_W)
   ) u_ent (
      .clk(clk), .rst_n(rst_n),
      .q_vpn(lk_vpn), .q_asid(lk_asid), .q_ns(lk_ns),
      .match_vec(match_vec), .valid_vec(valid_vec),
      .e_pfn(e_pfn), .e_mask(e_mask), .e_perm(e_perm), .e_xn(e_xn),
      .wr_en(rf_valid), .wr_idx(victim_idx),
      .wr_vpn(rf_vpn), .wr_mask(rf_mask), .wr_asid(rf_asid), .wr_ns(rf_ns),
      .wr_global(rf_global), .wr_pfn(rf_pfn), .wr_perm(rf_perm), .wr_xn(rf_xn),
      .clr_all(inv_all), .clr_asid_en(inv_asid_en), .clr_asid(inv_asid)
   );

   xlt_hit_select #(.N(N_ENTRIES)) u_sel (
      .match_vec(match_vec), .any_hit(any_hit), .many_hit(many_hit), .hit_idx(hit_idx)
   );

   xlt_victim_sel #(
      .N(N_ENTRIES), .LFSR_W(LFSR_W), .LFSR_TAPS(LFSR_TAPS), .LFSR_SEED(LFSR_SEED)
   ) u_vict (
      .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .rand_mode(repl_random),
      .alloc(rf_valid), .victim_idx(victim_idx)
   );

   assign sel_pfn  = e_pfn[hit_idx];
   assign sel_mask = e_mask[hit_idx];

   // masked low bits pass the virtual offset through to the frame
   if (PFN_W > MASK_W) begin : g_merge_wide
      assign merged_pfn = {sel_pfn[PFN_W-1:MASK_W],
                           (sel_pfn[MASK_W-1:0] & ~sel_mask) | (lk_vpn[MASK_W-1:0] & sel_mask)};
   end else begin : g_merge_full
      assign merged_pfn = (sel_pfn & ~sel_mask) | (lk_vpn[MASK_W-1:0] & sel_mask);
   end

   assign lk_hit   = lk_valid && any_hit;
   assign lk_multi = lk_valid && many_hit;
   assign lk_pfn   = lk_hit ? merged_pfn : '0;
   assign lk_fault = lk_hit && perm_fault(e_perm[hit_idx], e_xn[hit_idx], lk_write, lk_exec);
endmodule

// File: rtl/xlt_micro_cache_chk.sv
module xlt_micro_cache_chk #(
   parameter int N_ENTRIES = 32,
   parameter int LFSR_W    = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         lk_hit,
   input logic                         lk_multi,
   input logic                         rf_valid,
   input logic                         inv_all,
   input logic                         inv_asid_en,
   input logic                         repl_random,
   input logic [N_ENTRIES-1:0]         valid_vec,
   input logic [$clog2(N_ENTRIES)-1:0] victim_idx,
   input logic [$clog2(N_ENTRIES)-1:0] rr_ptr,
   input logic [LFSR_W-1:0]            lfsr
);
   localparam int IDX_W = $clog2(N_ENTRIES);

   logic [IDX_W-1:0] last_victim;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_victim <= '0;
      else        last_victim <= victim_idx;
   end

   AST_FREE_SLOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && !(&valid_vec)) |-> !valid_vec[victim_idx]); // R6
   AST_REFILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      rf_valid |=> valid_vec[last_victim]); // R11
   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_all && !rf_valid) |=> (valid_vec == '0)); // R9
   AST_CLEAR_ALL_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_all && rf_valid) |=> ($countones(valid_vec) == 1)); // R11
   AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && (&valid_vec) && !repl_random) |=> (rr_ptr == IDX_W'($past(rr_ptr) + 1'b1))); // R7
   AST_RR_FROZEN_RANDOM: assert property (@(posedge clk) disable iff (!rst_n)
      repl_random |=> $stable(rr_ptr)); // R8
   AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0); // R8
   AST_MULTI_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_multi |-> lk_hit); // R5
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rf_valid && !inv_all && !inv_asid_en) |=> $stable(valid_vec)); // R13
endmodule

bind xlt_micro_cache xlt_micro_cache_chk #(
   .N_ENTRIES(N_ENTRIES), .LFSR_W(LFSR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .lk_multi(lk_multi),
   .rf_valid(rf_valid), .inv_all(inv_all), .inv_asid_en(inv_asid_en),
   .repl_random(repl_random), .valid_vec(valid_vec), .victim_idx(victim_idx),
   .rr_ptr(u_vict.rr_ptr), .lfsr(u_vict.lfsr)
);

// File: tb/xlt_micro_cache_tb.sv
module xlt_micro_cache_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_valid, lk_ns, lk_write, lk_exec;
   logic [19:0] lk_vpn;
   logic [7:0]  lk_asid;
   logic        lk_hit, lk_fault, lk_multi;
   logic [19:0] lk_pfn;
   logic        rf_valid, rf_ns, rf_global, rf_xn;
   logic [19:0] rf_vpn, rf_pfn;
   logic [7:0]  rf_mask, rf_asid;
   logic [1:0]  rf_perm;
   logic        inv_all, inv_asid_en, repl_random;
   logic [7:0]  inv_asid;

   int    n_tests = 0;
   int    n_fail  = 0;
   string phase   = "R12";
   bit    done    = 1'b0;

   always #10 clk = ~clk;

   xlt_micro_cache u_dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_ns(lk_ns),
      .lk_write(lk_write), .lk_exec(lk_exec),
      .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_fault(lk_fault), .lk_multi(lk_multi),
      .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_mask(rf_mask), .rf_asid(rf_asid),
      .rf_ns(rf_ns), .rf_global(rf_global), .rf_pfn(rf_pfn), .rf_perm(rf_perm),
      .rf_xn(rf_xn), .inv_all(inv_all), .inv_asid_en(inv_asid_en),
      .inv_asid(inv_asid), .repl_random(repl_random)
   );

   // ---------------- reference model ----------------
   bit          mv [32], mg [32], mns [32], mxn [32];
   logic [19:0] mvpn [32], mpfn [32];
   logic [7:0]  masid [32], mmask [32];
   logic [1:0]  mperm [32];
   int          m_rr = 0;
   logic [15:0] m_lfsr = 16'hACE1;

   initial for (int i = 0; i < 32; i++) mv[i] = 1'b0;

   always @(posedge clk) begin
      int  vic;
      bit  full;
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) mv[i] = 1'b0;
         m_rr   = 0;
         m_lfsr = 16'hACE1;
      end else begin
         full = 1'b1;
         vic  = -1;
         for (int i = 0; i < 32; i++) if (!mv[i] && vic < 0) begin vic = i; full = 1'b0; end
         if (full) vic = repl_random ? int'(m_lfsr[4:0]) : m_rr;
         if (inv_all) begin
            for (int i = 0; i < 32; i++) mv[i] = 1'b0;
         end else if (inv_asid_en) begin
            for (int i = 0; i < 32; i++) if (!mg[i] && masid[i] == inv_asid) mv[i] = 1'b0;
         end
         if (rf_valid) begin
            mv[vic] = 1'b1; mg[vic] = rf_global; mns[vic] = rf_ns; mxn[vic] = rf_xn;
            mvpn[vic] = rf_vpn; mpfn[vic] = rf_pfn; masid[vic] = rf_asid;
            mmask[vic] = rf_mask; mperm[vic] = rf_perm;
            if (full && !repl_random) m_rr = (m_rr + 1) % 32;
         end
         m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0000);
      end
   end

   // compare every cycle, between edges
   always @(negedge clk) begin
      int          first, cnt;
      bit          eh, ef, em;
      logic [19:0] ep, msk;
      #5;
      first = -1; cnt = 0;
      for (int i = 0; i < 32; i++) begin
         msk = {12'h000, mmask[i]};
         if (mv[i] && (((mvpn[i] ^ lk_vpn) & ~msk) == 20'h0) && mns[i] == lk_ns
             && (mg[i] || masid[i] == lk_asid)) begin
            cnt++;
            if (first < 0) first = i;
         end
      end
      eh = lk_valid && cnt > 0;
      em = lk_valid && cnt > 1;
      ep = 20'h0; ef = 1'b0;
      if (eh) begin
         msk = {12'h000, mmask[first]};
         ep  = (mpfn[first] & ~msk) | (lk_vpn & msk);
         ef  = (mperm[first] == 2'b00) || (lk_write && mperm[first] == 2'b01)
               || (lk_exec && mxn[first]);
      end
      n_tests++;
      if (lk_hit !== eh) begin
         n_fail++; $display("FAIL [%s/R2] lk_hit act=%0b exp=%0b", phase, lk_hit, eh);
      end else if (lk_pfn !== ep) begin
         n_fail++; $display("FAIL [%s/R3] lk_pfn act=%h exp=%h", phase, lk_pfn, ep);
      end else if (lk_fault !== ef) begin
         n_fail++; $display("FAIL [%s/R4] lk_fault act=%0b exp=%0b", phase, lk_fault, ef);
      end else if (lk_multi !== em) begin
         n_fail++; $display("FAIL [%s/R5] lk_multi act=%0b exp=%0b", phase, lk_multi, em);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle();
      lk_valid = 0; lk_vpn = '0; lk_asid = '0; lk_ns = 0; lk_write = 0; lk_exec = 0;
      rf_valid = 0; rf_vpn = '0; rf_mask = '0; rf_asid = '0; rf_ns = 0; rf_global = 0;
      rf_pfn = '0; rf_perm = '0; rf_xn = 0; inv_all = 0; inv_asid_en = 0; inv_asid = '0;
   endtask

   task automatic set_look(input logic [19:0] v, input logic [7:0] a, input bit ns,
                           input bit wr, input bit ex);
      lk_valid = 1; lk_vpn = v; lk_asid = a; lk_ns = ns; lk_write = wr; lk_exec = ex;
   endtask

   task automatic set_fill(input logic [19:0] v, input logic [7:0] m, input logic [7:0] a,
                           input bit ns, input bit g, input logic [19:0] p,
                           input logic [1:0] pm, input bit xn);
      rf_valid = 1; rf_vpn = v; rf_mask = m; rf_asid = a; rf_ns = ns; rf_global = g;
      rf_pfn = p; rf_perm = pm; rf_xn = xn;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic look(input logic [19:0] v, input logic [7:0] a, input bit ns,
                       input bit wr, input bit ex);
      set_look(v, a, ns, wr, ex); step();
   endtask

   task automatic fill(input logic [19:0] v, input logic [7:0] m, input logic [7:0] a,
                       input bit ns, input bit g, input logic [19:0] p,
                       input logic [1:0] pm, input bit xn);
      set_fill(v, m, a, ns, g, p, pm, xn); step();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL [watchdog] run did not finish act=hung exp=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      idle();
      repl_random = 0;
      rst_n = 0;
      phase = "R12";
      set_look(20'h00100, 8'd5, 0, 0, 0);
      repeat (4) @(negedge clk);
      rst_n = 1;
      idle();

      phase = "R1";
      look(20'h00100, 8'd5, 0, 0, 0);
      step();

      phase = "R2";
      fill(20'h00100, 8'h00, 8'd5, 0, 0, 20'h0AAAA, 2'b10, 0);
      fill(20'h00200, 8'h00, 8'd9, 0, 1, 20'h0BBBB, 2'b11, 0);
      look(20'h00100, 8'd5, 0, 0, 0);
      look(20'h00100, 8'd6, 0, 0, 0);
      look(20'h00100, 8'd5, 1, 0, 0);
      look(20'h00200, 8'd3, 0, 0, 0);
      look(20'h00200, 8'd3, 1, 0, 0);
      look(20'h00101, 8'd5, 0, 0, 0);

      phase = "R3";
      fill(20'h00340, 8'h0F, 8'd5, 0, 0, 20'h12340, 2'b10, 0);
      look(20'h0034B, 8'd5, 0, 0, 0);
      look(20'h00340, 8'd5, 0, 0, 0);
      look(20'h0035B, 8'd5, 0, 0, 0);

      phase = "R4";
      fill(20'h00400, 8'h00, 8'd5, 0, 0, 20'h00401, 2'b00, 0);
      fill(20'h00500, 8'h00, 8'd5, 0, 0, 20'h00501, 2'b01, 0);
      fill(20'h00600, 8'h00, 8'd5, 0, 0, 20'h00601, 2'b10, 1);
      for (int k = 0; k < 4; k++) begin
         look(20'h00400, 8'd5, 0, k[0], k[1]);
         look(20'h00500, 8'd5, 0, k[0], k[1]);
         look(20'h00600, 8'd5, 0, k[0], k[1]);
      end

      phase = "R5";
      fill(20'h00100, 8'h00, 8'd5, 0, 0, 20'h0CCCC, 2'b01, 1);
      look(20'h00100, 8'd5, 0, 1, 1);
      look(20'h00100, 8'd5, 0, 0, 0);

      phase = "R13";
      set_fill(20'h00700, 8'h00, 8'd5, 0, 0, 20'h00777, 2'b10, 0);
      set_look(20'h00700, 8'd5, 0, 0, 0);
      step();
      look(20'h00700, 8'd5, 0, 0, 0);

      phase = "R6";
      for (int k = 0; k < 24; k++) fill(20'h01000 + k, 8'h00, 8'd7, 0, 0, 20'h20000 + k, 2'b10, 0);
      phase = "R7";
      for (int k = 0; k < 10; k++) fill(20'h02000 + k, 8'h00, 8'd7, 0, 0, 20'h30000 + k, 2'b10, 0);
      for (int k = 0; k < 24; k++) look(20'h01000 + k, 8'd7, 0, 0, 0);
      for (int k = 0; k < 10; k++) look(20'h02000 + k, 8'd7, 0, 0, 0);
      look(20'h00100, 8'd5, 0, 0, 0);
      look(20'h00200, 8'd1, 0, 0, 0);

      phase = "R10";
      inv_asid_en = 1; inv_asid = 8'd7; step();
      for (int k = 0; k < 10; k++) look(20'h02000 + k, 8'd7, 0, 0, 0);
      look(20'h00200, 8'd7, 0, 0, 0);
      fill(20'h00800, 8'h00, 8'd7, 1, 0, 20'h00888, 2'b10, 0);
      fill(20'h00900, 8'h00, 8'd7, 0, 1, 20'h00999, 2'b10, 0);
      inv_asid_en = 1; inv_asid = 8'd7; step();
      look(20'h00800, 8'd7, 1, 0, 0);
      look(20'h00900, 8'd2, 0, 0, 0);

      phase = "R11";
      set_fill(20'h00A00, 8'h00, 8'd5, 0, 0, 20'h00AAA, 2'b10, 0);
      inv_asid_en = 1; inv_asid = 8'd5;
      step();
      look(20'h00A00, 8'd5, 0, 0, 0);
      look(20'h00500, 8'd5, 0, 0, 0);
      look(20'h00200, 8'd5, 0, 0, 0);

      phase = "R9";
      inv_all = 1; step();
      look(20'h00A00, 8'd5, 0, 0, 0);
      look(20'h00200, 8'd9, 0, 0, 0);
      phase = "R11";
      fill(20'h00B00, 8'h00, 8'd3, 0, 0, 20'h00BBB, 2'b10, 0);
      set_fill(20'h00C00, 8'h00, 8'd3, 0, 0, 20'h00CCC, 2'b10, 0);
      inv_all = 1;
      step();
      look(20'h00C00, 8'd3, 0, 0, 0);
      look(20'h00B00, 8'd3, 0, 0, 0);

      phase = "R8";
      inv_all = 1; step();
      repl_random = 1;
      for (int k = 0; k < 32; k++) fill(20'h03000 + k, 8'h00, 8'd4, 0, 0, 20'h40000 + k, 2'b10, 0);
      for (int k = 0; k < 12; k++) begin
         fill(20'h04000 + k, 8'h00, 8'd4, 0, 0, 20'h50000 + k, 2'b10, 0);
         step();
      end
      for (int k = 0; k < 32; k++) look(20'h03000 + k, 8'd4, 0, 0, 0);
      for (int k = 0; k < 12; k++) look(20'h04000 + k, 8'd4, 0, 0, 0);
      repl_random = 0;
      phase = "R7";
      for (int k = 0; k < 6; k++) fill(20'h05000 + k, 8'h00, 8'd4, 0, 0, 20'h60000 + k, 2'b10, 0);
      for (int k = 0; k < 32; k++) look(20'h03000 + k, 8'd4, 0, 0, 0);

      phase = "R2";
      for (int c = 0; c < 6000; c++) begin
         if ($urandom_range(0, 99) < 70)
            set_look(20'h00010 * $urandom_range(0, 7) + 20'($urandom_range(0, 15)),
                     8'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
         if ($urandom_range(0, 99) < 25)
            set_fill(20'h00010 * $urandom_range(0, 7) + 20'($urandom_range(0, 15)),
                     ($urandom_range(0, 3) == 0) ? 8'h0F : 8'h00,
                     8'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                     ($urandom_range(0, 5) == 0), 20'($urandom),
                     2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
         if ($urandom_range(0, 99) < 3) begin
            inv_asid_en = 1; inv_asid = 8'($urandom_range(0, 3));
         end
         if ($urandom_range(0, 499) == 0) inv_all = 1;
         if ($urandom_range(0, 199) == 0) repl_random = ~repl_random;
         step();
      end

      step();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule